// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block is a shifter for 16-bit data. It places the operand in the upper or lower half of a 32-bit field and shifts that field left or right by a signed count. The shift can be logical or arithmetic. The result lands in a 32-bit register one clock after the operation is presented. An OR-merge option combines the new shifted value with the value already in the result register. This lets multiword values be built from 16-bit pieces.

The same path also handles floating-point style work. It can count the redundant sign bits of an operand (exponent derivation). It can shift an operand left by that count (normalize). It can shift an operand right by a supplied exponent (denormalize). A running-minimum register tracks the smallest exponent derived since it was last cleared. The whole array can then be scaled to one shared block exponent.

Top module: `normShifter`

## Requirements
- R1: After reset, `result` is 0, `expOut` is 0 and `blkExp` is 15.
- R2: With `opValid` high and `opSel`=0 (logical shift), `result` takes the positioned operand shifted on the next clock edge. A positive `amount` shifts left. A negative `amount` shifts right, and vacated bits are zeros.
- R3: With `opSel`=1 (arithmetic shift), left shifts fill with zeros. Right shifts fill vacated bits with bit 31 of the positioned operand.
- R4: A shift whose magnitude is 32 or more gives all zeros. The one exception is a right shift in an arithmetic mode, which gives all copies of the positioned sign bit.
- R5: When `hiLo` is 1, the operand occupies bits 31:16 and bits 15:0 are zero before shifting. When `hiLo` is 0, the operand occupies bits 15:0. Bits 31:16 are then zero for `opSel`=0 and copies of operand bit 15 for `opSel` 1, 2 and 3.
- R6: When `orMode` is 1 on a result-writing operation, the new `result` is the bitwise OR of the old `result` and the shifted value. Otherwise the shifted value replaces it.
- R7: With `opSel`=4 (derive exponent), `expOut` becomes the number of bits below bit 15 that equal bit 15 before the first differing bit. The range is 0 to 15, and 0x0000 and 0xFFFF give 15. `result` is unchanged.
- R8: With `opSel`=2 (normalize), the operand is shifted left arithmetically by its own derived exponent, and `amount` is ignored. `expOut` takes that exponent at the same time.
- R9: With `opSel`=3 (denormalize), the operand is shifted arithmetically right by `amount`. A negative `amount` shifts left by its magnitude.
- R10: `blkExp` takes the smaller of itself and the derived exponent on each `opSel`=4 operation. `blkClear` sets it to 15, and a clear in the same cycle takes priority over the update. Other operations leave it unchanged.
- R11: When `opValid` is low, or `opSel` is 5, 6 or 7, `result` and `expOut` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opSel | input | 3 | 0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent |
| hiLo | input | 1 | 1 places the operand in the upper half, 0 in the lower half |
| orMode | input | 1 | Merge the new value into the existing result |
| amount | input | 7 | Signed shift count or exponent (two's complement) |
| dataIn | input | 16 | Operand |
| blkClear | input | 1 | Reset the block exponent to 15 |
| result | output | 32 | Registered shift result |
| expOut | output | 4 | Registered derived exponent |
| blkExp | output | 4 | Running minimum exponent |

## Verification
The hard cases to reach from the ports are the edges of the count range and the interaction of the block-exponent register with clears. One edge is a count of exactly -64: its magnitude only fits after widening. Another is a count of exactly 32, where shifting stops and saturation takes over. The stimulus drives those counts directly in both placements and both fill modes. It then issues exponent derivations whose minimum falls in the middle of a sequence, and a clear in the same cycle as a derivation, so that clear priority is observed at `blkExp`. A long random phase follows, mixing OR-merges with unused operation codes.

// File: rtl/normShiftPkg.sv
package normShiftPkg;

  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } shOpE;

  typedef enum logic [1:0] {
    AMT_DIRECT = 2'd0,
    AMT_NEG    = 2'd1,
    AMT_EXP    = 2'd2
  } amtSrcE;

  typedef struct packed {
    logic   ldResult;
    logic   ldExp;
    logic   updBlk;
    logic   clrBlk;
    logic   arith;
    logic   orMode;
    logic   hiLo;
    amtSrcE amtSrc;
  } shCtrlS;

endpackage

// File: rtl/normShiftCtrl.sv
module normShiftCtrl
  import normShiftPkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opSel,
  input  logic       hiLo,
  input  logic       orMode,
  input  logic       blkClear,
  output shCtrlS     ctl
);

  always_comb begin
    ctl          = '0;
    ctl.amtSrc   = AMT_DIRECT;
    ctl.hiLo     = hiLo;
    ctl.orMode   = orMode;
    ctl.clrBlk   = blkClear;
    if (opValid) begin
      case (opSel)
        OP_LSH: begin
          ctl.ldResult = 1'b1;
        end
        OP_ASH: begin
          ctl.ldResult = 1'b1;
          ctl.arith    = 1'b1;
        end
        OP_NORM: begin
          ctl.ldResult = 1'b1;
          ctl.ldExp    = 1'b1;
          ctl.arith    = 1'b1;
          ctl.amtSrc   = AMT_EXP;
        end
        OP_DENORM: begin
          ctl.ldResult = 1'b1;
          ctl.arith    = 1'b1;
          ctl.amtSrc   = AMT_NEG;
        end
        OP_EXP: begin
          ctl.ldExp    = 1'b1;
          ctl.updBlk   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/normShiftPath.sv
module normShiftPath
  import normShiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  shCtrlS                      ctl,
  input  logic [AMT_W-1:0]            amount,
  input  logic [DATA_W-1:0]           dataIn,
  output logic [2*DATA_W-1:0]         result,
  output logic [$clog2(DATA_W)-1:0]   expOut,
  output logic [$clog2(DATA_W)-1:0]   blkExp
);

  localparam int RES_W = 2 * DATA_W;
  localparam int EXP_W = $clog2(DATA_W);
  localparam int SH_W  = AMT_W + 1;
  localparam int STG   = $clog2(RES_W);
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(DATA_W - 1);

  // exponent: redundant sign bits below the MSB
  logic [EXP_W-1:0] derivedExp;
  always_comb begin
    logic stillSign;
    derivedExp = '0;
    stillSign  = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (stillSign && (dataIn[i] == dataIn[DATA_W-1]))
        derivedExp = derivedExp + EXP_W'(1);
      else
        stillSign = 1'b0;
    end
  end

  // operand placement in the wide field
  logic [RES_W-1:0] placed;
  always_comb begin
    if (ctl.hiLo)
      placed = {dataIn, {DATA_W{1'b0}}};
    else
      placed = {{DATA_W{ctl.arith & dataIn[DATA_W-1]}}, dataIn};
  end

  // effective signed count
  logic signed [SH_W-1:0] directAmt, effAmt;
  logic        [SH_W-1:0] mag;
  assign directAmt = $signed({amount[AMT_W-1], amount});
  always_comb begin
    case (ctl.amtSrc)
      AMT_NEG: effAmt = -directAmt;
      AMT_EXP: effAmt = $signed({{(SH_W-EXP_W){1'b0}}, derivedExp});
      default: effAmt = directAmt;
    endcase
  end
  assign mag = effAmt[SH_W-1] ? SH_W'(-effAmt) : SH_W'(effAmt);

  logic fillBit, saturate, goLeft;
  assign fillBit  = ctl.arith & placed[RES_W-1];
  assign saturate = |mag[SH_W-1:STG];
  assign goLeft   = ~effAmt[SH_W-1];

  // logarithmic barrel stages
  logic [RES_W-1:0] lStage [STG+1];
  logic [RES_W-1:0] rStage [STG+1];
  assign lStage[0] = placed;
  assign rStage[0] = placed;
  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int D = 1 << s;
    assign lStage[s+1] = mag[s] ? {lStage[s][RES_W-1-D:0], {D{1'b0}}} : lStage[s];
    assign rStage[s+1] = mag[s] ? {{D{fillBit}}, rStage[s][RES_W-1:D]} : rStage[s];
  end

  logic [RES_W-1:0] shifted;
  always_comb begin
    if (goLeft)
      shifted = saturate ? '0 : lStage[STG];
    else
      shifted = saturate ? {RES_W{fillBit}} : rStage[STG];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      expOut <= '0;
      blkExp <= EXP_MAX;
    end else begin
      if (ctl.ldResult)
        result <= ctl.orMode ? (result | shifted) : shifted;
      if (ctl.ldExp)
        expOut <= derivedExp;
      if (ctl.clrBlk)
        blkExp <= EXP_MAX;
      else if (ctl.updBlk && (derivedExp < blkExp))
        blkExp <= derivedExp;
    end
  end

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldResult |=> $stable(result));

  // R6
  or_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldResult && ctl.orMode) |=> ((result & $past(result)) == $past(result)));

  // R10
  blk_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrBlk |=> (blkExp <= $past(blkExp)));

endmodule

// File: rtl/normShifter.sv
module normShifter
  import normShiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      opValid,
  input  logic [2:0]                opSel,
  input  logic                      hiLo,
  input  logic                      orMode,
  input  logic [AMT_W-1:0]          amount,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic                      blkClear,
  output logic [2*DATA_W-1:0]       result,
  output logic [$clog2(DATA_W)-1:0] expOut,
  output logic [$clog2(DATA_W)-1:0] blkExp
);

  shCtrlS ctl;

  normShiftCtrl ctrl_i (
    .opValid (opValid),
    .opSel   (opSel),
    .hiLo    (hiLo),
    .orMode  (orMode),
    .blkClear(blkClear),
    .ctl     (ctl)
  );

  normShiftPath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) path_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .amount(amount),
    .dataIn(dataIn),
    .result(result),
    .expOut(expOut),
    .blkExp(blkExp)
  );

  // R8
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd2 && hiLo && !orMode &&
     dataIn != '0 && dataIn != '1)
    |=> (result[2*DATA_W-1] != result[2*DATA_W-2]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(result) && $stable(expOut)));

endmodule

// File: tb/normShifter_tb_top.sv
module normShifter_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opSel;
  logic        hiLo;
  logic        orMode;
  logic [6:0]  amount;
  logic [15:0] dataIn;
  logic        blkClear;
  logic [31:0] result;
  logic [3:0]  expOut;
  logic [3:0]  blkExp;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] mRes;
  int          mExp;
  int          mBlk;

  always #5 clk = ~clk;

  normShifter dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .hiLo(hiLo),
    .orMode(orMode), .amount(amount), .dataIn(dataIn), .blkClear(blkClear),
    .result(result), .expOut(expOut), .blkExp(blkExp)
  );

  function automatic int refExp(logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] refShift(logic [15:0] d, logic hl, logic ar, int amt);
    logic [31:0] p;
    logic f;
    p = hl ? {d, 16'h0} : (ar ? {{16{d[15]}}, d} : {16'h0, d});
    f = ar & p[31];
    if (amt >= 0) begin
      for (int k = 0; k < amt; k++) p = {p[30:0], 1'b0};
    end else begin
      for (int k = 0; k < -amt; k++) p = {f, p[31:1]};
    end
    return p;
  endfunction

  task automatic checkAll(string tag);
    total++;
    if (result !== mRes) begin
      bad++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, mRes);
    end
    total++;
    if (int'(expOut) != mExp) begin
      bad++;
      $display("FAIL %s expOut actual=%0d expected=%0d", tag, expOut, mExp);
    end
    total++;
    if (int'(blkExp) != mBlk) begin
      bad++;
      $display("FAIL %s blkExp actual=%0d expected=%0d", tag, blkExp, mBlk);
    end
  endtask

  // called at a falling edge: drive, update model, advance, compare
  task automatic step(string tag, logic v, logic [2:0] op, logic hl, logic om,
                      int amt, logic [15:0] d, logic clr);
    logic [31:0] sh = '0;
    bit ld = 0;
    int e;
    opValid = v; opSel = op; hiLo = hl; orMode = om;
    amount = 7'(amt); dataIn = d; blkClear = clr;
    e = refExp(d);
    if (v) begin
      case (op)
        3'd0: begin sh = refShift(d, hl, 1'b0, amt); ld = 1; end
        3'd1: begin sh = refShift(d, hl, 1'b1, amt); ld = 1; end
        3'd2: begin sh = refShift(d, hl, 1'b1, e); ld = 1; mExp = e; end
        3'd3: begin sh = refShift(d, hl, 1'b1, -amt); ld = 1; end
        3'd4: begin mExp = e; if (!clr && e < mBlk) mBlk = e; end
        default: ;
      endcase
    end
    if (clr) mBlk = 15;
    if (ld) mRes = om ? (mRes | sh) : sh;
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 0; opSel = 0; hiLo = 0; orMode = 0;
    amount = 0; dataIn = 0; blkClear = 0;
    mRes = 0; mExp = 0; mBlk = 15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");

    // R2 logical shifts
    step("R2 lsh left",  1, 0, 1, 0,   4, 16'h1234, 0);
    step("R2 lsh right", 1, 0, 1, 0,  -3, 16'h8421, 0);
    step("R2 lsh lo",    1, 0, 0, 0,   5, 16'hF00F, 0);
    // R3 arithmetic shifts
    step("R3 ash right neg", 1, 1, 0, 0, -4, 16'h8001, 0);
    step("R3 ash right hi",  1, 1, 1, 0, -9, 16'hC000, 0);
    step("R3 ash left",      1, 1, 0, 0,  7, 16'h7FFF, 0);
    // R4 saturation
    step("R4 lsh 32",  1, 0, 0, 0,  32, 16'hFFFF, 0);
    step("R4 lsh -40", 1, 0, 1, 0, -40, 16'hFFFF, 0);
    step("R4 ash -64", 1, 1, 1, 0, -64, 16'h8000, 0);
    step("R4 ash -32 pos", 1, 1, 1, 0, -32, 16'h4000, 0);
    step("R4 ash 63",  1, 1, 0, 0,  63, 16'h8000, 0);
    step("R4 ash 31",  1, 1, 0, 0,  31, 16'h0001, 0);
    // R5 placement
    step("R5 lo zero-ext", 1, 0, 0, 0, 0, 16'h9ABC, 0);
    step("R5 lo sign-ext", 1, 1, 0, 0, 0, 16'h9ABC, 0);
    step("R5 hi",          1, 1, 1, 0, 0, 16'h9ABC, 0);
    // R6 OR merge
    step("R6 upper", 1, 0, 1, 0, 0, 16'hA5A5, 0);
    step("R6 merge", 1, 0, 0, 1, 0, 16'h3C3C, 0);
    step("R6 merge shifted", 1, 1, 0, 1, 8, 16'h0081, 0);
    // R7 exponent
    step("R7 exp 0F00", 1, 4, 0, 0, 0, 16'h0F00, 0);
    step("R7 exp zero", 1, 4, 0, 0, 0, 16'h0000, 0);
    step("R7 exp 8000", 1, 4, 0, 0, 0, 16'h8000, 0);
    step("R7 exp FFFE", 1, 4, 0, 0, 0, 16'hFFFE, 0);
    // R8 normalize
    step("R8 norm pos", 1, 2, 1, 0, 10, 16'h0123, 0);
    step("R8 norm neg", 1, 2, 1, 0, -5, 16'hFF80, 0);
    step("R8 norm lo",  1, 2, 0, 0, 0,  16'h0003, 0);
    // R9 denormalize
    step("R9 denorm",      1, 3, 1, 0,  4, 16'h8000, 0);
    step("R9 denorm neg",  1, 3, 0, 0, -3, 16'h0011, 0);
    step("R9 denorm far",  1, 3, 1, 0, 40, 16'h9000, 0);
    // R10 block exponent
    step("R10 clear",  0, 0, 0, 0, 0, 16'h0000, 1);
    step("R10 exp 7",  1, 4, 0, 0, 0, 16'h00FF, 0);
    step("R10 exp 3",  1, 4, 0, 0, 0, 16'h0FFF, 0);
    step("R10 exp 9",  1, 4, 0, 0, 0, 16'h003F, 0);
    step("R10 norm no upd", 1, 2, 0, 0, 0, 16'h4000, 0);
    step("R10 clear wins", 1, 4, 0, 0, 0, 16'h4000, 1);
    // R11 ignored operations
    step("R11 idle",   0, 0, 1, 0, 3, 16'hFFFF, 0);
    step("R11 code 5", 1, 5, 1, 0, 3, 16'h1111, 0);
    step("R11 code 6", 1, 6, 0, 1, -2, 16'h2222, 0);
    step("R11 code 7", 1, 7, 1, 0, 9, 16'h3333, 0);

    // random mix across all requirements
    for (int n = 0; n < 600; n++) begin
      int a = int'($urandom_range(0, 127)) - 64;
      step("R2-mix random", 1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), a,
           16'($urandom), 1'($urandom_range(0, 15) == 0));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule